// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block sits in a 64-bit load/store pipeline and keeps one atomic reservation. Each operation arrives already decoded as a 10-bit extended opcode, a byte effective address, store data and the current summary-overflow bit. A load-and-reserve reads memory, returns the value zero-extended to 64 bits and records the address and access size. A later store-conditional writes memory only if that same reservation is still present. It then reports a 4-bit condition field and always drops the reservation. A snoop port lets another agent invalidate the reservation by writing any byte it covers.

Memory sits outside the block and is organised as 8-byte words with byte lanes. Byte `k` of a word lives in lane `k`, on data bits `8k+7:8k`, which makes the lanes little-endian. Requests are driven combinationally in the cycle an operation is accepted. Read data comes back one clock later.

Two enumerated machines do the work. The operation machine has the states OP_IDLE and OP_READ. It moves OP_IDLE→OP_READ when a read (plain or reserving) is accepted, and it always moves OP_READ→OP_IDLE after one cycle. The reservation machine has the states RSV_EMPTY and RSV_HELD. It moves RSV_EMPTY→RSV_HELD on a load-and-reserve and stays in RSV_HELD on a further load-and-reserve, which replaces the recorded address and size. It moves RSV_HELD→RSV_EMPTY on any store-conditional or on a snoop hit.

Top module: `lrsc_monitor`

## Requirements
- R1: Decode uses these opcodes:
  - load-and-reserve: 52 (byte), 116 (half), 20 (word), 84 (double);
  - store-conditional: 694, 726, 150, 214 (same sizes, same order);
  - plain loads: 87, 279, 23, 21;
  - plain stores: 215, 407, 151, 149;
  - any other opcode makes no memory access and has no other effect.

  `mem_re` and `mem_we` are never high together.
- R2: An accepted load-and-reserve sets `rsv_valid` at the next edge. It records the exact address in `rsv_addr` and the size in `rsv_size`, coded 0=1, 1=2, 2=4, 3=8 bytes. It replaces any earlier reservation.
- R3: A store-conditional succeeds only when the reservation is valid, `rsv_addr` equals its address, and `rsv_size` equals its size.
- R4: Every store-conditional clears the reservation at the next edge, whether it succeeds or fails.
- R5: One edge after a store-conditional is accepted, `cr_valid` pulses for one cycle. At the same time `cr_field` = {LT, GT, EQ, SO} = {0, 0, success, `so_bit`}, giving 0010 on success and 0000 on failure, with SO ORed into bit 0.
- R6: `mem_we` is high for a plain store always, and for a store-conditional only on success. `mem_be` marks the accessed bytes starting at lane `ea[2:0]`. `mem_wdata` carries the store data shifted into those lanes.
- R7: Read data is returned on `ld_data`, zero-extended from the access size, with `ld_valid` high two edges after acceptance. `op_ready` is low in the cycle in between.
- R8: A snoop whose address lies between `rsv_addr` and `rsv_addr` + size − 1 (inclusive) clears the reservation at the next edge. Any other snoop address has no effect. A load-and-reserve accepted in the same cycle wins over the snoop.
- R9: Plain loads and stores leave the reservation valid flag, address and size unchanged.
- R10: Reset empties the reservation and clears `cr_valid` and `ld_valid`. `op_ready` is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation presented |
| op_xop | input | 10 | Extended opcode |
| op_ea | input | 64 | Byte effective address |
| op_st_data | input | 64 | Store data, right-aligned |
| so_bit | input | 1 | Current summary-overflow bit |
| op_ready | output | 1 | Block can accept an operation |
| snoop_valid | input | 1 | Remote write observed |
| snoop_addr | input | 64 | Byte address of remote write |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_be | output | 8 | Byte-lane strobes |
| mem_addr | output | 64 | Word-aligned memory address |
| mem_wdata | output | 64 | Lane-aligned write data |
| mem_rdata | input | 64 | Read word, one cycle after request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Zero-extended load result |
| cr_valid | output | 1 | Condition result valid |
| cr_field | output | 4 | LT, GT, EQ, SO |
| rsv_valid | output | 1 | Reservation held |
| rsv_addr | output | 64 | Reserved address |
| rsv_size | output | 2 | Reserved size code |

## Verification
Memory requests (`mem_re`, `mem_we`, `mem_be`) are combinational, so the bench reads them 1 ns after it drives the operation, before the accepting edge. Reservation changes, `cr_valid` and `cr_field` are due one edge after acceptance, and load data is due two edges after. Snoop effects are due one edge after the snoop is presented. Every scenario task therefore drives on a falling edge and reads each result on the falling edge that follows the edge at which that result is due.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    localparam int XOP_W = 10;

    typedef enum logic [2:0] {
        K_NONE,
        K_LOAD,
        K_STORE,
        K_LR,
        K_SC
    } op_kind_e;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } op_size_e;

    typedef enum logic {
        OP_IDLE,
        OP_READ
    } op_state_e;

    typedef enum logic {
        RSV_EMPTY,
        RSV_HELD
    } rsv_state_e;

    typedef struct packed {
        op_kind_e kind;
        op_size_e size;
    } op_dec_t;

    localparam logic [XOP_W-1:0] XO_LR_B = 10'd52;
    localparam logic [XOP_W-1:0] XO_LR_H = 10'd116;
    localparam logic [XOP_W-1:0] XO_LR_W = 10'd20;
    localparam logic [XOP_W-1:0] XO_LR_D = 10'd84;
    localparam logic [XOP_W-1:0] XO_SC_B = 10'd694;
    localparam logic [XOP_W-1:0] XO_SC_H = 10'd726;
    localparam logic [XOP_W-1:0] XO_SC_W = 10'd150;
    localparam logic [XOP_W-1:0] XO_SC_D = 10'd214;
    localparam logic [XOP_W-1:0] XO_LD_B = 10'd87;
    localparam logic [XOP_W-1:0] XO_LD_H = 10'd279;
    localparam logic [XOP_W-1:0] XO_LD_W = 10'd23;
    localparam logic [XOP_W-1:0] XO_LD_D = 10'd21;
    localparam logic [XOP_W-1:0] XO_ST_B = 10'd215;
    localparam logic [XOP_W-1:0] XO_ST_H = 10'd407;
    localparam logic [XOP_W-1:0] XO_ST_W = 10'd151;
    localparam logic [XOP_W-1:0] XO_ST_D = 10'd149;

endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
    import lrsc_pkg::*;
(
    input  logic [XOP_W-1:0] xop,
    output op_dec_t          dec
);

    always_comb begin
        dec = '{kind: K_NONE, size: SZ_B};
        unique case (xop)
            XO_LR_B: dec = '{kind: K_LR,    size: SZ_B};
            XO_LR_H: dec = '{kind: K_LR,    size: SZ_H};
            XO_LR_W: dec = '{kind: K_LR,    size: SZ_W};
            XO_LR_D: dec = '{kind: K_LR,    size: SZ_D};
            XO_SC_B: dec = '{kind: K_SC,    size: SZ_B};
            XO_SC_H: dec = '{kind: K_SC,    size: SZ_H};
            XO_SC_W: dec = '{kind: K_SC,    size: SZ_W};
            XO_SC_D: dec = '{kind: K_SC,    size: SZ_D};
            XO_LD_B: dec = '{kind: K_LOAD,  size: SZ_B};
            XO_LD_H: dec = '{kind: K_LOAD,  size: SZ_H};
            XO_LD_W: dec = '{kind: K_LOAD,  size: SZ_W};
            XO_LD_D: dec = '{kind: K_LOAD,  size: SZ_D};
            XO_ST_B: dec = '{kind: K_STORE, size: SZ_B};
            XO_ST_H: dec = '{kind: K_STORE, size: SZ_H};
            XO_ST_W: dec = '{kind: K_STORE, size: SZ_W};
            XO_ST_D: dec = '{kind: K_STORE, size: SZ_D};
            default: dec = '{kind: K_NONE,  size: SZ_B};
        endcase
    end

endmodule

// File: rtl/lrsc_st_align.sv
module lrsc_st_align
    import lrsc_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [OFF_W-1:0]  off,
    input  op_size_e          size,
    input  logic [DATA_W-1:0] st_data,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);

    logic [LANES-1:0] size_lanes;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            size_lanes[i] = (i < (32'sd1 <<< int'(size)));
        end
        be    = size_lanes << off;
        wdata = st_data << {off, 3'b000};
    end

endmodule

// File: rtl/lrsc_ld_extract.sv
module lrsc_ld_extract
    import lrsc_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [OFF_W-1:0]  off,
    input  op_size_e          size,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] ld_ext
);

    logic [LANES-1:0]  keep;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            keep[i] = (i < (32'sd1 <<< int'(size)));
        end
        shifted = rd_word >> {off, 3'b000};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ld_ext[8*g +: 8] = keep[g] ? shifted[8*g +: 8] : 8'h00;
    end

endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  op_size_e          set_size,
    input  logic              sc_en,
    input  logic [ADDR_W-1:0] sc_addr,
    input  op_size_e          sc_size,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              sc_pass,
    output logic              rsv_valid,
    output logic [ADDR_W-1:0] rsv_addr,
    output op_size_e          rsv_size
);

    rsv_state_e        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    op_size_e          size_q;
    logic [ADDR_W-1:0] snoop_off;
    logic [ADDR_W-1:0] span;
    logic              snoop_hit;

    always_comb begin
        snoop_off = snoop_addr - addr_q;
        span      = ADDR_W'(1) << size_q;
        snoop_hit = snoop_valid && (state == RSV_HELD) && (snoop_off < span);
        sc_pass   = (state == RSV_HELD) && (addr_q == sc_addr) && (size_q == sc_size);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RSV_EMPTY: if (set_en) state_nx = RSV_HELD;
            RSV_HELD: begin
                if (set_en)                  state_nx = RSV_HELD;
                else if (sc_en || snoop_hit) state_nx = RSV_EMPTY;
            end
            default: state_nx = RSV_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RSV_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            size_q <= SZ_B;
        end else if (set_en) begin
            addr_q <= set_addr;
            size_q <= set_size;
        end
    end

    assign rsv_valid = (state == RSV_HELD);
    assign rsv_addr  = addr_q;
    assign rsv_size  = size_q;

    // R4
    sc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_en && !set_en) |=> !rsv_valid);

    // R8
    snoop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && rsv_valid && snoop_addr == rsv_addr && !set_en) |=> !rsv_valid);

    // R8
    snoop_lr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && snoop_valid) |=> rsv_valid);

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [XOP_W-1:0]  op_xop,
    input  logic [ADDR_W-1:0] op_ea,
    input  logic [DATA_W-1:0] op_st_data,
    input  logic              so_bit,
    output logic              op_ready,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [LANES-1:0]  mem_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data,
    output logic              cr_valid,
    output logic [3:0]        cr_field,
    output logic              rsv_valid,
    output logic [ADDR_W-1:0] rsv_addr,
    output logic [1:0]        rsv_size
);

    op_state_e         state, state_nx;
    op_dec_t           dec;
    logic              accept;
    logic              is_read;
    logic              sc_pass;
    logic              set_en;
    logic              sc_en;
    op_size_e          rsv_size_e;
    logic [LANES-1:0]  st_be;
    logic [DATA_W-1:0] st_wdata;
    logic [OFF_W-1:0]  cap_off;
    op_size_e          cap_size;
    logic [DATA_W-1:0] ld_ext;

    lrsc_decode u_decode (
        .xop (op_xop),
        .dec (dec)
    );

    lrsc_st_align #(.DATA_W(DATA_W)) u_st_align (
        .off     (op_ea[OFF_W-1:0]),
        .size    (dec.size),
        .st_data (op_st_data),
        .be      (st_be),
        .wdata   (st_wdata)
    );

    lrsc_ld_extract #(.DATA_W(DATA_W)) u_ld_extract (
        .off     (cap_off),
        .size    (cap_size),
        .rd_word (mem_rdata),
        .ld_ext  (ld_ext)
    );

    lrsc_resv #(.ADDR_W(ADDR_W)) u_resv (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (set_en),
        .set_addr    (op_ea),
        .set_size    (dec.size),
        .sc_en       (sc_en),
        .sc_addr     (op_ea),
        .sc_size     (dec.size),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .sc_pass     (sc_pass),
        .rsv_valid   (rsv_valid),
        .rsv_addr    (rsv_addr),
        .rsv_size    (rsv_size_e)
    );

    assign rsv_size = rsv_size_e;

    always_comb begin
        op_ready  = (state == OP_IDLE);
        accept    = op_valid && op_ready;
        is_read   = (dec.kind == K_LOAD) || (dec.kind == K_LR);
        set_en    = accept && (dec.kind == K_LR);
        sc_en     = accept && (dec.kind == K_SC);
        mem_re    = accept && is_read;
        mem_we    = accept && ((dec.kind == K_STORE) || ((dec.kind == K_SC) && sc_pass));
        mem_be    = mem_we ? st_be : '0;
        mem_addr  = {op_ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_wdata = st_wdata;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OP_IDLE: if (accept && is_read) state_nx = OP_READ;
            OP_READ: state_nx = OP_IDLE;
            default: state_nx = OP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OP_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr_valid <= 1'b0;
            cr_field <= 4'b0000;
            ld_valid <= 1'b0;
            ld_data  <= '0;
            cap_off  <= '0;
            cap_size <= SZ_B;
        end else begin
            cr_valid <= sc_en;
            if (sc_en) cr_field <= {2'b00, sc_pass, so_bit};
            ld_valid <= (state == OP_READ);
            if (state == OP_READ) ld_data <= ld_ext;
            if (accept && is_read) begin
                cap_off  <= op_ea[OFF_W-1:0];
                cap_size <= dec.size;
            end
        end
    end

    // R1
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_re, mem_we}));

    // R2
    lr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.kind == K_LR) |=> (rsv_valid && rsv_addr == $past(op_ea)));

    // R3
    sc_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.kind == K_SC && mem_we) |-> (rsv_valid && rsv_addr == op_ea));

    // R5
    cr_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid |-> (cr_field[3:2] == 2'b00 && cr_field[0] == $past(so_bit)));

    // R7
    ld_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_read) |=> (!op_ready ##1 ld_valid));

    // R9
    plain_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (dec.kind == K_LOAD || dec.kind == K_STORE) && !snoop_valid)
        |=> ($stable(rsv_valid) && $stable(rsv_addr)));

endmodule

// File: tb/lrsc_monitor_bench.sv
module lrsc_monitor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [9:0]  op_xop = '0;
    logic [63:0] op_ea = '0;
    logic [63:0] op_st_data = '0;
    logic        so_bit = 1'b0;
    logic        op_ready;
    logic        snoop_valid = 1'b0;
    logic [63:0] snoop_addr = '0;
    logic        mem_re, mem_we;
    logic [7:0]  mem_be;
    logic [63:0] mem_addr, mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        ld_valid;
    logic [63:0] ld_data;
    logic        cr_valid;
    logic [3:0]  cr_field;
    logic        rsv_valid;
    logic [63:0] rsv_addr;
    logic [1:0]  rsv_size;

    logic [7:0]  mem [0:255];
    int          total = 0;
    int          bad = 0;
    logic        done = 1'b0;
    logic        seen_re, seen_we;
    logic [7:0]  seen_be;

    always #10 clk = ~clk;

    lrsc_monitor u_lrsc_monitor (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_xop(op_xop),
        .op_ea(op_ea), .op_st_data(op_st_data), .so_bit(so_bit), .op_ready(op_ready),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data), .cr_valid(cr_valid), .cr_field(cr_field),
        .rsv_valid(rsv_valid), .rsv_addr(rsv_addr), .rsv_size(rsv_size)
    );

    always @(posedge clk) begin
        for (int i = 0; i < 8; i++) begin
            if (mem_we && mem_be[i]) mem[mem_addr[7:0] + 8'(i)] <= mem_wdata[8*i +: 8];
            if (mem_re) mem_rdata[8*i +: 8] <= mem[mem_addr[7:0] + 8'(i)];
        end
    end

    function automatic logic [63:0] ref_load(input logic [63:0] a, input int nbytes);
        logic [63:0] r = '0;
        for (int k = 0; k < nbytes; k++) r[8*k +: 8] = mem[a[7:0] + 8'(k)];
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one op; capture comb requests; return on the falling edge after acceptance.
    task automatic issue(input logic [9:0] x, input logic [63:0] a,
                         input logic [63:0] d, input logic so);
        @(negedge clk);
        op_valid = 1'b1; op_xop = x; op_ea = a; op_st_data = d; so_bit = so;
        #1;
        seen_re = mem_re; seen_we = mem_we; seen_be = mem_be;
        @(negedge clk);
        op_valid = 1'b0; so_bit = 1'b0;
    endtask

    task automatic do_load(input logic [9:0] x, input logic [63:0] a,
                           input int nbytes, input string req);
        logic [63:0] expv = ref_load(a, nbytes);
        issue(x, a, 64'h0, 1'b0);
        chk({req, " read request"}, {63'h0, seen_re}, 64'h1);
        @(negedge clk);
        chk({req, " ld_valid"}, {63'h0, ld_valid}, 64'h1);
        chk({req, " ld_data"}, ld_data, expv);
    endtask

    task automatic t_reset;
        chk("R10 rsv_valid", {63'h0, rsv_valid}, 64'h0);
        chk("R10 op_ready", {63'h0, op_ready}, 64'h1);
        chk("R10 cr_valid", {63'h0, cr_valid}, 64'h0);
    endtask

    task automatic t_word_pair;
        do_load(10'd20, 64'h10, 4, "R7 LR word");
        chk("R2 rsv_valid", {63'h0, rsv_valid}, 64'h1);
        chk("R2 rsv_addr", rsv_addr, 64'h10);
        chk("R2 rsv_size", {62'h0, rsv_size}, 64'h2);
        issue(10'd150, 64'h10, 64'h1234_5678_CAFE_F00D, 1'b0);
        chk("R6 SC we", {63'h0, seen_we}, 64'h1);
        chk("R6 SC be", {56'h0, seen_be}, 64'h0F);
        chk("R5 cr_valid", {63'h0, cr_valid}, 64'h1);
        chk("R3 success cr", {60'h0, cr_field}, 64'h2);
        chk("R4 cleared after success", {63'h0, rsv_valid}, 64'h0);
        chk("R6 memory written", ref_load(64'h10, 4), 64'hCAFE_F00D);
    endtask

    task automatic t_zero_ext_size_mismatch;
        mem[8'h32] = 8'hFF;
        mem[8'h33] = 8'h77;
        do_load(10'd52, 64'h32, 1, "R7 LR byte zero-ext");
        chk("R2 byte size", {62'h0, rsv_size}, 64'h0);
        issue(10'd726, 64'h32, 64'hAAAA, 1'b0);
        chk("R3 size mismatch no write", {63'h0, seen_we}, 64'h0);
        chk("R3 size mismatch cr", {60'h0, cr_field}, 64'h0);
        chk("R4 cleared after fail", {63'h0, rsv_valid}, 64'h0);
        chk("R3 memory untouched", ref_load(64'h32, 2), 64'h77FF);
    endtask

    task automatic t_no_reservation;
        issue(10'd214, 64'h20, 64'h1, 1'b1);
        chk("R3 no reservation no write", {63'h0, seen_we}, 64'h0);
        chk("R5 fail with SO", {60'h0, cr_field}, 64'h1);
    endtask

    task automatic t_addr_mismatch;
        do_load(10'd84, 64'h20, 8, "R7 LR dword");
        issue(10'd214, 64'h28, 64'h5, 1'b0);
        chk("R3 address mismatch cr", {60'h0, cr_field}, 64'h0);
        chk("R4 cleared after mismatch", {63'h0, rsv_valid}, 64'h0);
    endtask

    task automatic t_so_success_lanes;
        do_load(10'd116, 64'h46, 2, "R7 LR half");
        issue(10'd726, 64'h46, 64'hBEEF, 1'b1);
        chk("R5 success with SO", {60'h0, cr_field}, 64'h3);
        chk("R6 high lanes", {56'h0, seen_be}, 64'hC0);
        chk("R6 half stored", ref_load(64'h46, 2), 64'hBEEF);
    endtask

    task automatic t_replace;
        do_load(10'd20, 64'h10, 4, "R7 LR first");
        do_load(10'd116, 64'h46, 2, "R7 LR second");
        chk("R2 replaced addr", rsv_addr, 64'h46);
        chk("R2 replaced size", {62'h0, rsv_size}, 64'h1);
        issue(10'd150, 64'h10, 64'h9, 1'b0);
        chk("R2 old reservation gone", {60'h0, cr_field}, 64'h0);
    endtask

    task automatic t_snoop;
        do_load(10'd20, 64'h50, 4, "R7 LR snoop setup");
        snoop_valid = 1'b1; snoop_addr = 64'h54;
        @(negedge clk);
        snoop_valid = 1'b0;
        chk("R8 snoop past end ignored", {63'h0, rsv_valid}, 64'h1);
        snoop_valid = 1'b1; snoop_addr = 64'h53;
        @(negedge clk);
        snoop_valid = 1'b0;
        chk("R8 snoop last byte clears", {63'h0, rsv_valid}, 64'h0);
        issue(10'd150, 64'h50, 64'h1, 1'b0);
        chk("R8 SC after snoop fails", {60'h0, cr_field}, 64'h0);
    endtask

    task automatic t_plain_ops;
        do_load(10'd84, 64'h60, 8, "R7 LR plain setup");
        issue(10'd149, 64'h70, 64'h0102_0304_0506_0708, 1'b0);
        chk("R6 plain store we", {63'h0, seen_we}, 64'h1);
        chk("R6 plain store be", {56'h0, seen_be}, 64'hFF);
        do_load(10'd21, 64'h70, 8, "R7 plain load");
        chk("R9 reservation kept", {63'h0, rsv_valid}, 64'h1);
        chk("R9 address kept", rsv_addr, 64'h60);
        issue(10'd214, 64'h60, 64'h42, 1'b0);
        chk("R9 SC still succeeds", {60'h0, cr_field}, 64'h2);
    endtask

    task automatic t_unknown;
        do_load(10'd20, 64'h80, 4, "R7 LR unknown setup");
        issue(10'd5, 64'h80, 64'h1, 1'b0);
        chk("R1 unknown no read", {63'h0, seen_re}, 64'h0);
        chk("R1 unknown no write", {63'h0, seen_we}, 64'h0);
        chk("R1 unknown no cr", {63'h0, cr_valid}, 64'h0);
        chk("R1 unknown keeps reservation", {63'h0, rsv_valid}, 64'h1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + 5);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_pair();
        t_zero_ext_size_mismatch();
        t_no_reservation();
        t_addr_mismatch();
        t_so_success_lanes();
        t_replace();
        t_snoop();
        t_plain_ops();
        t_unknown();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule